// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide, that is looked up by content instead of by address. A search command captures a search value (the argument) and a bit mask (the key) into internal registers. Every stored entry is then compared with the argument at the same time, but only in the bit positions where the key holds a 1. The result is a match vector with one bit per entry. Each entry carries a valid flag: it is set when the entry is written, and an entry that has never been written never matches.

After the compare, the block walks the match vector from entry 0 upward and presents each matching entry on the read port, one per cycle, together with its index and a data strobe. A one-cycle done pulse follows the last beat. When nothing matches, a no-match flag is raised and done arrives with no beats at all. Entries are written by address through a separate write port. Writes and searches are accepted only while the block reports ready, so a write that arrives during a search is held off until the search has finished.

The controller has four states. IDLE accepts commands. On a search it moves to LOAD, which compares and latches the match vector. LOAD goes to STEP when anything matched and to FINISH otherwise. STEP emits one entry per cycle and moves to FINISH after emitting the last pending match. FINISH emits done and returns to IDLE.

Top module: `mask_cam`

## Requirements
- R1: After reset, `ready` is 1, `match_vec` is all zero, and `nomatch`, `out_valid` and `done` are 0.
- R2: A write is accepted on a clock edge where `wr_req` and `ready` are both 1. It stores `wr_data` at entry `wr_addr` and marks that entry valid, replacing any earlier content.
- R3: A search is accepted on an edge where `srch_req` and `ready` are both 1. On the following edge, bit i of `match_vec` is set to 1 exactly when entry i is valid and ((entry XOR `srch_arg`) AND `srch_key`) is zero. `match_vec` then holds that value until the next search updates it.
- R4: A key of all zeros makes every valid entry match, whatever the argument.
- R5: An entry that has never been written never matches, for any argument and key.
- R6: Matching entries are read out in ascending index order, one per cycle, with `out_valid` = 1 and `out_idx` and `out_data` giving the entry. The first beat appears one cycle after `match_vec` is updated, and there are no gaps between beats.
- R7: `done` is a single-cycle pulse. It appears in the cycle right after the last beat, or one cycle after the `match_vec` update when there are no matches. It never coincides with `out_valid`.
- R8: `nomatch` is updated together with `match_vec` and is 1 exactly when the new match vector is all zero. No beats follow a no-match search.
- R9: `ready` is 0 from the edge that accepts a search until the cycle in which `done` is high, when it returns to 1. A write or search presented while `ready` is 0 has no effect, so a requester must hold its request until `ready` is 1.
- R10: When a write and a search are accepted on the same edge, the search compares against the contents as updated by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_addr | input | IDXW | Entry index to write |
| wr_data | input | WIDTH | Data to store |
| srch_req | input | 1 | Search request |
| srch_arg | input | WIDTH | Search argument |
| srch_key | input | WIDTH | Compare mask; 1 = bit takes part |
| ready | output | 1 | Block idle; write and search accepted |
| match_vec | output | WORDS | Match register, one bit per entry |
| nomatch | output | 1 | Last search found no entry |
| out_valid | output | 1 | Readout beat strobe |
| out_idx | output | IDXW | Index of the entry on the read port |
| out_data | output | WIDTH | Contents of the entry on the read port |
| done | output | 1 | End-of-readout pulse |

## Verification
Some properties are checked by assertions on every cycle:
- a beat never points at an entry whose match bit is clear, and beat indices strictly increase;
- `done` lasts one cycle and never overlaps a beat;
- no beat and no busy-time `ready` appear around a no-match result;
- a set match bit always belongs to a valid entry;
- an accepted write validates its entry.

Other properties only show up in the bench's scenarios, where a cycle-accurate reference model supplies the expected values:
- the masked compare gives the exact match values for each mix of argument and key;
- the stored data comes back correct in the beats;
- requests made while busy are really dropped;
- a search issued together with a write sees the new contents.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_FINISH
    } cam_state_e;

endpackage

// File: rtl/cam_word_array.sv
module cam_word_array #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    parameter int IDXW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [WORDS-1:0] hit,
    output logic [WORDS-1:0] valid,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] word_q [WORDS];
    logic [WORDS-1:0] valid_q;

    // storage: data has no reset, only the valid flags do
    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (wr_en && (wr_addr == IDXW'(w))) begin
                word_q[w] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_en && (wr_addr == IDXW'(w))) begin
                    valid_q[w] <= 1'b1;
                end
            end
        end
    end

    // one masked comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        logic [WIDTH-1:0] same_bit;
        always_comb begin
            same_bit = (arg & word_q[g]) | (~arg & ~word_q[g]);
            hit[g]   = valid_q[g] && (&(same_bit | ~key));
        end
    end

    assign valid   = valid_q;
    assign rd_word = word_q[rd_idx];

endmodule

// File: rtl/cam_first_set.sv
module cam_first_set #(
    parameter int WORDS = 8,
    parameter int IDXW  = 3
) (
    input  logic [WORDS-1:0] vec,
    output logic [IDXW-1:0]  idx,
    output logic [WORDS-1:0] onehot,
    output logic             last
);

    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDXW'(i);
            end
        end
    end

    assign onehot = vec & (~vec + WORDS'(1));
    assign last   = (vec != '0) && ((vec & ~onehot) == '0);

endmodule

// File: rtl/mask_cam.sv
module mask_cam #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [IDXW-1:0]  wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             srch_req,
    input  logic [WIDTH-1:0] srch_arg,
    input  logic [WIDTH-1:0] srch_key,
    output logic             ready,
    output logic [WORDS-1:0] match_vec,
    output logic             nomatch,
    output logic             out_valid,
    output logic [IDXW-1:0]  out_idx,
    output logic [WIDTH-1:0] out_data,
    output logic             done
);

    import cam_pkg::*;

    cam_state_e       state_q, state_d;
    logic [WIDTH-1:0] arg_q, key_q;
    logic [WORDS-1:0] match_q, pend_q;
    logic             nomatch_q;
    logic             out_valid_q, done_q;
    logic [IDXW-1:0]  out_idx_q;
    logic [WIDTH-1:0] out_data_q;

    logic             idle;
    logic             wr_en;
    logic [WORDS-1:0] hit;
    logic [WORDS-1:0] valid_vec;
    logic [WIDTH-1:0] rd_word;
    logic [IDXW-1:0]  pick_idx;
    logic [WORDS-1:0] pick_onehot;
    logic             pick_last;

    assign idle  = (state_q == ST_IDLE);
    assign wr_en = wr_req && idle;

    cam_word_array #(
        .WORDS (WORDS),
        .WIDTH (WIDTH),
        .IDXW  (IDXW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .arg     (arg_q),
        .key     (key_q),
        .rd_idx  (pick_idx),
        .hit     (hit),
        .valid   (valid_vec),
        .rd_word (rd_word)
    );

    cam_first_set #(
        .WORDS (WORDS),
        .IDXW  (IDXW)
    ) u_pick (
        .vec    (pend_q),
        .idx    (pick_idx),
        .onehot (pick_onehot),
        .last   (pick_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (srch_req) state_d = ST_LOAD;
            ST_LOAD:   state_d = (hit != '0) ? ST_STEP : ST_FINISH;
            ST_STEP:   if (pick_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q       <= '0;
            key_q       <= '0;
            match_q     <= '0;
            pend_q      <= '0;
            nomatch_q   <= 1'b0;
            out_valid_q <= 1'b0;
            out_idx_q   <= '0;
            out_data_q  <= '0;
            done_q      <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            done_q      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (srch_req) begin
                        arg_q <= srch_arg;
                        key_q <= srch_key;
                    end
                end
                ST_LOAD: begin
                    match_q   <= hit;
                    pend_q    <= hit;
                    nomatch_q <= (hit == '0);
                end
                ST_STEP: begin
                    out_valid_q <= 1'b1;
                    out_idx_q   <= pick_idx;
                    out_data_q  <= rd_word;
                    pend_q      <= pend_q & ~pick_onehot;
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ready     = idle;
    assign match_vec = match_q;
    assign nomatch   = nomatch_q;
    assign out_valid = out_valid_q;
    assign out_idx   = out_idx_q;
    assign out_data  = out_data_q;
    assign done      = done_q;

endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
    parameter int WORDS = 8,
    parameter int IDXW  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_req,
    input logic [IDXW-1:0]  wr_addr,
    input logic             ready,
    input logic [WORDS-1:0] match_vec,
    input logic [WORDS-1:0] valid_vec,
    input logic             nomatch,
    input logic             out_valid,
    input logic [IDXW-1:0]  out_idx,
    input logic             done
);

    a_r2_write_validates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && ready) |=> valid_vec[$past(wr_addr)]);

    a_r5_match_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~valid_vec) == '0);

    a_r6_beat_is_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> match_vec[out_idx]);

    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_idx > $past(out_idx)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && out_valid));

    a_r8_nomatch_empty: assert property (@(posedge clk) disable iff (!rst_n)
        nomatch |-> ((match_vec == '0) && !out_valid));

    a_r9_busy_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ready);

    a_r9_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

endmodule

bind mask_cam cam_checker #(
    .WORDS (WORDS),
    .IDXW  (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .ready     (ready),
    .match_vec (match_vec),
    .valid_vec (valid_vec),
    .nomatch   (nomatch),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .done      (done)
);

// File: tb/sim_mask_cam.sv
module sim_mask_cam;

    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDXW  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_req = 1'b0;
    logic [IDXW-1:0]  wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             srch_req = 1'b0;
    logic [WIDTH-1:0] srch_arg = '0;
    logic [WIDTH-1:0] srch_key = '0;
    logic             ready;
    logic [WORDS-1:0] match_vec;
    logic             nomatch;
    logic             out_valid;
    logic [IDXW-1:0]  out_idx;
    logic [WIDTH-1:0] out_data;
    logic             done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mask_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .srch_req(srch_req), .srch_arg(srch_arg), .srch_key(srch_key),
        .ready(ready), .match_vec(match_vec), .nomatch(nomatch),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
        .done(done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [WIDTH-1:0] m_mem [WORDS];
    bit               m_val [WORDS];
    int               m_phase;   // 0 idle, 1 compare, 2 stream, 3 finish
    int               m_q[$];
    logic [WIDTH-1:0] m_arg, m_key;
    logic [WORDS-1:0] m_match;
    bit               m_nomatch, e_ov, e_done;
    int               e_idx;
    logic [WIDTH-1:0] e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) m_val[i] = 0;
            m_phase = 0; m_q = {}; m_match = '0; m_nomatch = 0;
            e_ov = 0; e_done = 0; e_idx = 0; e_data = '0;
        end else begin
            e_ov = 0;
            e_done = 0;
            case (m_phase)
                0: begin
                    if (wr_req) begin
                        m_mem[wr_addr] = wr_data;
                        m_val[wr_addr] = 1;
                    end
                    if (srch_req) begin
                        m_arg = srch_arg; m_key = srch_key; m_phase = 1;
                    end
                end
                1: begin
                    m_q = {};
                    for (int i = 0; i < WORDS; i++) begin
                        m_match[i] = m_val[i] && (((m_mem[i] ^ m_arg) & m_key) == 0);
                        if (m_match[i]) m_q.push_back(i);
                    end
                    m_nomatch = (m_q.size() == 0);
                    m_phase = m_nomatch ? 3 : 2;
                end
                2: begin
                    e_idx = m_q.pop_front();
                    e_ov = 1;
                    e_data = m_mem[e_idx];
                    if (m_q.size() == 0) m_phase = 3;
                end
                default: begin
                    e_done = 1;
                    m_phase = 0;
                end
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9", "ready", 64'(ready), 64'(m_phase == 0));
            chk("R3", "match_vec", 64'(match_vec), 64'(m_match));
            chk("R8", "nomatch", 64'(nomatch), 64'(m_nomatch));
            chk("R6", "out_valid", 64'(out_valid), 64'(e_ov));
            chk("R7", "done", 64'(done), 64'(e_done));
            if (e_ov) begin
                chk("R6", "out_idx", 64'(out_idx), 64'(e_idx));
                chk("R6", "out_data", 64'(out_data), 64'(e_data));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d);
        wait_ready();
        #1; wr_req = 1; wr_addr = IDXW'(a); wr_data = d;
        @(negedge clk); #1; wr_req = 0;
    endtask

    task automatic run_search(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k,
                              input int exp_beats, input string tag);
        int beats = 0;
        wait_ready();
        #1; srch_req = 1; srch_arg = a; srch_key = k;
        @(negedge clk); #1; srch_req = 0;
        while (!done) begin
            @(negedge clk);
            if (out_valid) beats++;
        end
        chk(tag, "beat count", 64'(beats), 64'(exp_beats));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int beats;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "ready after reset", 64'(ready), 64'd1);
        chk("R1", "match after reset", 64'(match_vec), 64'd0);
        chk("R1", "nomatch after reset", 64'(nomatch), 64'd0);
        chk("R1", "strobes after reset", 64'({out_valid, done}), 64'd0);

        // R5: empty array never matches, even with an open key
        run_search(16'h0000, 16'h0000, 0, "R5");
        chk("R5", "nomatch on empty", 64'(nomatch), 64'd1);

        do_write(0, 16'h1234);
        do_write(1, 16'h12FF);
        do_write(2, 16'hABCD);
        do_write(3, 16'h1200);
        do_write(5, 16'h1234);

        run_search(16'h1234, 16'hFFFF, 2, "R3");          // entries 0,5
        chk("R3", "full key vector", 64'(match_vec), 64'h21);
        run_search(16'h1200, 16'hFF00, 4, "R3");          // 0,1,3,5
        chk("R3", "upper byte vector", 64'(match_vec), 64'h2B);
        run_search(16'hBEEF, 16'h0000, 5, "R4");          // all valid
        chk("R4", "open key vector", 64'(match_vec), 64'h2F);
        chk("R5", "unwritten 4,6,7 absent", 64'(match_vec & 8'hD0), 64'd0);
        run_search(16'hFFFF, 16'hFFFF, 0, "R8");
        chk("R8", "nomatch raised", 64'(nomatch), 64'd1);

        // R9: busy-time requests; a pulsed write is lost, a held one waits
        wait_ready();
        #1; srch_req = 1; srch_arg = 16'h0; srch_key = 16'h0;
        @(negedge clk); #1; srch_req = 0;
        wr_req = 1; wr_addr = 3'd6; wr_data = 16'h5555;
        @(negedge clk); #1;
        wr_addr = 3'd4; wr_data = 16'h1234;   // held until ready
        beats = 0;
        if (out_valid) beats++;
        while (!done) begin
            @(negedge clk);
            if (out_valid) beats++;
        end
        chk("R9", "ready back with done", 64'(ready), 64'd1);
        @(negedge clk); #1; wr_req = 0;
        chk("R9", "beats while write stalled", 64'(beats), 64'd5);
        run_search(16'h5555, 16'hFFFF, 0, "R9");          // pulsed write lost
        run_search(16'h1234, 16'hFFFF, 3, "R9");          // 0,4,5

        // R10: write and search on the same edge
        wait_ready();
        #1; wr_req = 1; wr_addr = 3'd7; wr_data = 16'h7777;
        srch_req = 1; srch_arg = 16'h7777; srch_key = 16'hFFFF;
        @(negedge clk); #1; wr_req = 0; srch_req = 0;
        beats = 0;
        while (!done) begin
            @(negedge clk);
            if (out_valid) beats++;
        end
        chk("R10", "same-edge write seen", 64'(beats), 64'd1);

        // R2: overwrite replaces old content
        do_write(2, 16'h1234);
        run_search(16'h1234, 16'hFFFF, 4, "R2");          // 0,2,4,5
        run_search(16'hABCD, 16'hFFFF, 0, "R2");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule